// File: doc/BRIEF.md
# Word-to-Pin Bit Serializer with Level-Driven Transfer Requests

This block takes 32-bit words from a 16-entry internal FIFO and sends them out on one pin, one bit for each serializer tick and most significant bit first. A push port writes words into the FIFO. A small write-only register port sets the run controls: enable, FIFO clear, slot count (range), idle level, output inversion and re-send of the last word. The block also sets a thresholds register that drives two request lines to a transfer engine outside the block.

Each FIFO entry fills `range` bit slots. With a range of 32, each entry sends exactly one word. A smaller range sends only the leading bits of the word. A larger range fills the extra slots with the idle level. When the FIFO runs dry, the pin either rests at the idle level or replays the last word taken from the FIFO.

A request line asks for more data while FIFO occupancy is low. A second, urgent line uses its own threshold.

Top module: `word_serializer`

## Requirements
- R1: After reset the block is disabled, the pin is low, `fifo_level` and `wr_err` are 0, the range is 32 and both thresholds are 8.
- R2: Register writes use `cfg_addr` 0 for control, 1 for range (bits 7:0) and 2 for thresholds (request threshold in bits 4:0, urgent threshold in bits 12:8).
  - The control bits are: bit 0 enable, bit 1 clear (a pulse, not stored), bit 2 idle level, bit 3 invert, bit 4 repeat-last.
  - While enabled, each tick with `bit_tick` high shifts out one bit, MSB first. With range 32, each FIFO entry sends exactly its 32 bits, and the next entry follows with no gap.
- R3: A range R below 32 sends only bits 31 down to 32-R of each entry, then moves to the next entry.
- R4: A range R above 32 sends all 32 bits, then R-32 slots at the idle level.
- R5: When the FIFO is empty and repeat-last is clear, every tick drives the idle level.
- R6: When the FIFO is empty and repeat-last is set, the last entry taken from the FIFO is sent again, with the same range handling.
- R7: With invert clear, a 1 bit drives the pin high. With invert set, the pin is the complement, including the idle level.
- R8: While enabled, `dma_req` is high exactly when `fifo_level` is at or below the request threshold, and `dma_panic` is high exactly when it is at or below the urgent threshold. Both are low while disabled.
- R9: A push into a full FIFO (16 entries) is dropped, and `wr_err` is set and stays set.
- R10: A control write with the clear bit set empties the FIFO and clears `wr_err` on that clock edge.
- R11: Clearing enable stops shifting at once. The pin goes to the idle level (after inversion), no entry is popped while disabled, and the rest of the word in progress is discarded, so re-enabling starts on the next FIFO entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 13 | Register write data |
| push_valid | input | 1 | Push a word into the FIFO |
| push_data | input | 32 | Word to push |
| bit_tick | input | 1 | Serializer tick, one bit slot per high cycle |
| ser_pin | output | 1 | Serial output pin |
| dma_req | output | 1 | Request for more data |
| dma_panic | output | 1 | Urgent request for more data |
| fifo_level | output | 5 | FIFO occupancy, 0 to 16 |
| wr_err | output | 1 | Sticky push-while-full flag |

## Verification
The bench sweeps the range over values below, at and above 32. For each range it compares every slot against a bit computed arithmetically from the pushed words. A design with an off-by-one slot counter would shift the whole stream by a bit, and a design that sent LSB first would mirror every word.

The bench drains the FIFO with repeat-last both clear and set, and with both idle levels and inversion. A design that froze on the last bit, or that replayed the wrong word, would fail here.

It walks FIFO occupancy across both thresholds, at their defaults and after reprogramming, to catch comparisons with the wrong sense. It also overfills the FIFO and drops enable mid-word, which exposes pointer corruption and a pin that keeps toggling after enable falls.

// File: rtl/wser_pkg.sv
package wser_pkg;
    localparam int WORD_W    = 32;
    localparam int BIT_IDX_W = $clog2(WORD_W);
    localparam int RANGE_W   = 8;
    localparam int THR_W     = 5;
    localparam int ADDR_W    = 2;
    localparam int CFG_W     = 13;
    localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'(32);
    localparam logic [THR_W-1:0]   THR_RST   = THR_W'(8);

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_RANGE = 2'd1,
        REG_THR   = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic rpt_last;
        logic invert;
        logic idle_lvl;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [THR_W-1:0]   urgent_thr;
        logic [THR_W-1:0]   req_thr;
        logic [RANGE_W-1:0] range;
        ctrl_t              ctrl;
    } cfg_t;

    // Bit for slot idx of word w; slots past the word carry the idle level.
    function automatic logic slot_bit(input logic [WORD_W-1:0] w,
                                      input logic [RANGE_W-1:0] idx,
                                      input logic idle);
        logic [WORD_W-1:0] sh;
        sh = w << idx[BIT_IDX_W-1:0];
        if (idx < RANGE_W'(WORD_W))
            return sh[WORD_W-1];
        return idle;
    endfunction
endpackage

// File: rtl/wser_regs.sv
module wser_regs
    import wser_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output cfg_t                cfg,
    output logic                clr_pulse
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(cfg_addr);

    assign clr_pulse = cfg_we && (sel == REG_CTRL) && cfg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.ctrl       <= '0;
            cfg.range      <= RANGE_RST;
            cfg.req_thr    <= THR_RST;
            cfg.urgent_thr <= THR_RST;
        end else if (cfg_we) begin
            case (sel)
                REG_CTRL: begin
                    cfg.ctrl.enable   <= cfg_wdata[0];
                    cfg.ctrl.idle_lvl <= cfg_wdata[2];
                    cfg.ctrl.invert   <= cfg_wdata[3];
                    cfg.ctrl.rpt_last <= cfg_wdata[4];
                end
                REG_RANGE: cfg.range <= cfg_wdata[RANGE_W-1:0];
                REG_THR: begin
                    cfg.req_thr    <= cfg_wdata[THR_W-1:0];
                    cfg.urgent_thr <= cfg_wdata[8 +: THR_W];
                end
                default: ;
            endcase
        end
    end

    a_r1_reset_defaults: assert property (@(posedge clk)
        rst |=> (cfg.range == RANGE_RST && cfg.req_thr == THR_RST &&
                 cfg.urgent_thr == THR_RST && !cfg.ctrl.enable));
endmodule

// File: rtl/wser_fifo.sv
module wser_fifo
    import wser_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              wr_err
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rd_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            wr_err <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
            if (push && full) wr_err <= 1'b1;
        end
    end

    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));
    a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (full && wr_err));
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (empty && !wr_err));
endmodule

// File: rtl/wser_shifter.sv
module wser_shifter
    import wser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               tick,
    input  logic [RANGE_W-1:0] range,
    input  logic               idle_lvl,
    input  logic               rpt_last,
    input  logic               fifo_empty,
    input  logic [WORD_W-1:0]  fifo_data,
    output logic               pop,
    output logic               ser_bit
);
    logic [WORD_W-1:0]  cur_word, last_word, src;
    logic [RANGE_W-1:0] idx, eff_range;
    logic               busy, have_last, load;

    assign eff_range = (range == '0) ? RANGE_W'(1) : range;

    always_comb begin
        pop  = 1'b0;
        load = 1'b0;
        src  = fifo_data;
        if (en && tick && !busy) begin
            if (!fifo_empty) begin
                pop  = 1'b1;
                load = 1'b1;
            end else if (rpt_last && have_last) begin
                load = 1'b1;
                src  = last_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word  <= '0;
            last_word <= '0;
            idx       <= '0;
            busy      <= 1'b0;
            have_last <= 1'b0;
            ser_bit   <= 1'b0;
        end else if (!en) begin
            busy    <= 1'b0;
            idx     <= '0;
            ser_bit <= idle_lvl;
        end else if (tick) begin
            if (busy) begin
                ser_bit <= slot_bit(cur_word, idx, idle_lvl);
                idx     <= idx + RANGE_W'(1);
                if (idx >= eff_range - RANGE_W'(1)) busy <= 1'b0;
            end else if (load) begin
                cur_word <= src;
                ser_bit  <= slot_bit(src, '0, idle_lvl);
                idx      <= RANGE_W'(1);
                busy     <= (eff_range != RANGE_W'(1));
                if (pop) begin
                    last_word <= src;
                    have_last <= 1'b1;
                end
            end else begin
                ser_bit <= idle_lvl;
            end
        end
    end

    a_r11_halt_on_disable: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);
    a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty);
    a_r11_no_pop_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pop);
endmodule

// File: rtl/wser_levels.sv
module wser_levels
    import wser_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic              en,
    input  logic [LVL_W-1:0]  level,
    input  logic [THR_W-1:0]  req_thr,
    input  logic [THR_W-1:0]  urgent_thr,
    output logic              req,
    output logic              urgent
);
    assign req    = en && (int'(level) <= int'(req_thr));
    assign urgent = en && (int'(level) <= int'(urgent_thr));
endmodule

// File: rtl/word_serializer.sv
module word_serializer
    import wser_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              push_valid,
    input  logic [WORD_W-1:0] push_data,
    input  logic              bit_tick,
    output logic              ser_pin,
    output logic              dma_req,
    output logic              dma_panic,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              wr_err
);
    cfg_t              cfg;
    logic              clr_pulse, pop, empty, full, ser_bit;
    logic [WORD_W-1:0] head;

    wser_regs u_regs (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata,
        .cfg(cfg), .clr_pulse(clr_pulse)
    );

    wser_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk, .rst, .clr(clr_pulse), .push(push_valid), .push_data,
        .pop(pop), .rd_data(head), .level(fifo_level),
        .empty(empty), .full(full), .wr_err(wr_err)
    );

    wser_shifter u_shift (
        .clk, .rst, .en(cfg.ctrl.enable), .tick(bit_tick),
        .range(cfg.range), .idle_lvl(cfg.ctrl.idle_lvl),
        .rpt_last(cfg.ctrl.rpt_last), .fifo_empty(empty),
        .fifo_data(head), .pop(pop), .ser_bit(ser_bit)
    );

    wser_levels #(.LVL_W(LVL_W)) u_lvl (
        .en(cfg.ctrl.enable), .level(fifo_level),
        .req_thr(cfg.req_thr), .urgent_thr(cfg.urgent_thr),
        .req(dma_req), .urgent(dma_panic)
    );

    assign ser_pin = (cfg.ctrl.enable ? ser_bit : cfg.ctrl.idle_lvl) ^ cfg.ctrl.invert;

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !cfg.ctrl.enable |-> (!dma_req && !dma_panic));
    a_r8_urgent_implies_req: assert property (@(posedge clk) disable iff (rst)
        (cfg.urgent_thr <= cfg.req_thr && dma_panic) |-> dma_req);
    a_r9_full_level: assert property (@(posedge clk) disable iff (rst)
        full |-> (fifo_level == LVL_W'(DEPTH)));
endmodule

// File: tb/word_serializer_tb.sv
module word_serializer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [12:0] cfg_wdata = '0;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        bit_tick = 1'b0;
    logic        ser_pin, dma_req, dma_panic, wr_err;
    logic [4:0]  fifo_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] wbuf [16];

    word_serializer dut_i (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .push_valid, .push_data,
        .bit_tick, .ser_pin, .dma_req, .dma_panic, .fifo_level, .wr_err
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [12:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic ctrl(bit en, bit clr, bit idle, bit inv, bit rpt);
        wr(2'd0, {8'd0, rpt, inv, idle, clr, en});
    endtask

    task automatic push(logic [31:0] w);
        push_valid = 1'b1; push_data = w;
        step();
        push_valid = 1'b0;
    endtask

    // r == 0 keeps the current (default) range of 32.
    task automatic run_stream(int n, int r, bit idle, bit inv, bit rpt,
                              int nticks, string req);
        int R;
        R = (r == 0) ? 32 : r;
        ctrl(0, 1, idle, inv, rpt);
        if (r != 0) wr(2'd1, 13'(r));
        for (int i = 0; i < n; i++) begin
            wbuf[i] = 32'h9E3779B9 * 32'(i + 3 + r) ^ 32'(r << 7);
            push(wbuf[i]);
        end
        chk("R2", 32'(fifo_level), 32'(n));
        ctrl(1, 0, idle, inv, rpt);
        bit_tick = 1'b1;
        for (int k = 0; k < nticks; k++) begin
            int wi, pos;
            logic e;
            step();
            wi  = k / R;
            pos = k % R;
            if (wi >= n && rpt) wi = n - 1;
            if (wi >= n)       e = idle;
            else if (pos < 32) e = wbuf[wi][31 - pos];
            else               e = idle;
            chk(req, 32'(ser_pin), 32'(e ^ inv));
        end
        bit_tick = 1'b0;
        ctrl(0, 1, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1", 32'(ser_pin), 0);
        chk("R1", 32'(fifo_level), 0);
        chk("R1", 32'(wr_err), 0);
        chk("R1", 32'(dma_req), 0);
        chk("R1", 32'(dma_panic), 0);

        // R1 default range 32, R2 MSB first, R5 idle after drain
        run_stream(3, 0, 0, 0, 0, 3 * 32 + 8, "R2");
        run_stream(1, 0, 0, 0, 0, 32 + 6, "R5");

        // R3 truncation sweep
        run_stream(2, 1, 0, 0, 0, 8, "R3");
        run_stream(2, 5, 1, 0, 0, 14, "R3");
        run_stream(2, 31, 0, 0, 0, 66, "R3");
        run_stream(2, 32, 1, 0, 0, 70, "R2");
        // R4 padding sweep
        run_stream(2, 33, 1, 0, 0, 70, "R4");
        run_stream(2, 40, 1, 0, 0, 85, "R4");
        run_stream(2, 40, 0, 0, 0, 85, "R4");
        // R6 repeat-last
        run_stream(1, 8, 0, 0, 1, 32, "R6");
        run_stream(2, 36, 1, 0, 1, 150, "R6");
        // R7 invert
        run_stream(2, 32, 0, 1, 0, 70, "R7");
        run_stream(1, 34, 1, 1, 0, 40, "R7");

        // R8 thresholds, default 8 (R1) then reprogrammed
        ctrl(1, 1, 0, 0, 0);
        for (int k = 0; k <= 11; k++) begin
            chk("R8", 32'(dma_req), 32'(k <= 8));
            chk("R8", 32'(dma_panic), 32'(k <= 8));
            push(32'(k));
        end
        wr(2'd2, {5'd1, 3'd0, 5'd3});
        ctrl(1, 1, 0, 0, 0);
        for (int k = 0; k <= 5; k++) begin
            chk("R8", 32'(dma_req), 32'(k <= 3));
            chk("R8", 32'(dma_panic), 32'(k <= 1));
            push(32'(k));
        end
        ctrl(0, 0, 0, 0, 0);
        chk("R8", 32'(dma_req), 0);
        chk("R8", 32'(dma_panic), 0);

        // R9 overflow, R10 clear
        ctrl(0, 1, 0, 0, 0);
        for (int k = 0; k < 16; k++) push(32'(k));
        chk("R9", 32'(wr_err), 0);
        push(32'hDEAD);
        chk("R9", 32'(fifo_level), 16);
        chk("R9", 32'(wr_err), 1);
        push(32'hBEEF);
        chk("R9", 32'(wr_err), 1);
        ctrl(0, 1, 0, 0, 0);
        chk("R10", 32'(fifo_level), 0);
        chk("R10", 32'(wr_err), 0);

        // R11 disable mid-word
        wr(2'd1, 13'd32);
        wbuf[0] = 32'hF0F0_1234;
        wbuf[1] = 32'h5A5A_8001;
        push(wbuf[0]);
        push(wbuf[1]);
        ctrl(1, 0, 1, 0, 0);
        bit_tick = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            chk("R11", 32'(ser_pin), 32'(wbuf[0][31 - k]));
        end
        bit_tick = 1'b0;
        ctrl(0, 0, 1, 1, 0);
        chk("R11", 32'(ser_pin), 0);
        chk("R11", 32'(fifo_level), 1);
        bit_tick = 1'b1;
        repeat (5) step();
        chk("R11", 32'(fifo_level), 1);
        chk("R11", 32'(ser_pin), 0);
        bit_tick = 1'b0;
        ctrl(1, 0, 1, 0, 0);
        bit_tick = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R11", 32'(ser_pin), 32'(wbuf[1][31 - k]));
        end
        bit_tick = 1'b0;
        chk("R11", 32'(fifo_level), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule